// File: doc/BRIEF.md
# Carrier Board Host Register Block

This block sits on the 8-bit I/O bus of a host computer and gives software control of a carrier board that holds a row of processor modules. It claims a window of twenty byte addresses at one of two base addresses, chosen by a strap input. The four lowest offsets belong to an external serial link adaptor, and accesses to them are passed straight through. The block itself holds the registers for the reset and analyse lines of the modules, the combined error readback, the byte-wise DMA engine's direction and request logic, and the interrupt enables.

A DMA transfer starts when software writes the DMA register. The block then raises a request to the host DMA controller for one byte at a time, but only while the adaptor can take or supply a byte in the chosen direction. An acknowledge that carries the terminal count ends the transfer and latches an end-of-transfer event. Four event sources are each gated by an enable bit and merged onto a single interrupt line.

Top module: `hbc_top`

## Requirements
- R1: With `base_sel` low the window is 0x150 to 0x163; with it high the window is 0x200 to 0x213. An access outside the window leaves every register unchanged, asserts no adaptor select and reads 0x00.
- R2: An access at offsets 0x00 to 0x03 asserts `la_cs` with `la_offs` equal to the offset, `la_wr` or `la_rd` matching the access, and a read returns `la_rdata`.
- R3: A write at offset 0x10 sets `mod_reset` to data bit 0 from the following clock.
- R4: A read at offset 0x10 returns, in bit 0, the OR of all `mod_err` bits, with bits 7:1 zero.
- R5: A write at offset 0x11 sets `mod_analyse` to data bit 0 from the following clock.
- R6: A write at offset 0x12 starts a transfer with direction equal to data bit 0 (0: host to board, paced by `la_out_rdy`; 1: board to host, paced by `la_in_rdy`). A read at 0x12 returns the active flag in bit 1 and the direction in bit 0.
- R7: `dma_req` is high in a cycle exactly when, in the previous cycle, a transfer was active, the adaptor was ready for its direction and `dma_ack` was low; so it drops for at least one cycle after every acknowledged byte.
- R8: A cycle with `dma_ack` and `dma_tc` both high ends the transfer and sets the end-of-transfer event; the next write at offset 0x12 clears that event. A write at 0x12 in the same cycle takes priority.
- R9: A write at offset 0x13 loads the enables from data bits 3:0. One clock later `irq` is the OR of: bit 0 and the end-of-transfer event, bit 1 and the error OR, bit 2 and `la_out_rdy`, bit 3 and `la_in_rdy`.
- R10: After reset all outputs and registers are zero. Offsets 0x04 to 0x0F and reads of 0x11 and 0x13 return 0x00, and writes to 0x04 to 0x0F change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low |
| base_sel | input | 1 | Base address strap: 0 gives 0x150, 1 gives 0x200 |
| addr | input | 10 | I/O address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| la_cs | output | 1 | Link adaptor select |
| la_wr | output | 1 | Link adaptor write |
| la_rd | output | 1 | Link adaptor read |
| la_offs | output | 2 | Link adaptor register offset |
| la_wdata | output | 8 | Link adaptor write data |
| la_rdata | input | 8 | Link adaptor read data |
| la_in_rdy | input | 1 | Adaptor holds a byte for the host |
| la_out_rdy | input | 1 | Adaptor can accept a byte from the host |
| mod_err | input | NMOD | Error lines of the modules |
| mod_reset | output | 1 | Module reset drive |
| mod_analyse | output | 1 | Module analyse drive |
| dma_req | output | 1 | DMA request, one byte at a time |
| dma_ack | input | 1 | DMA acknowledge |
| dma_tc | input | 1 | Terminal count, valid with acknowledge |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with three module error lines and the default base addresses, which keeps both windows and the gap between them within a short address sweep. Three error lines let a single bit in the middle, an edge bit and no bit at all be set against the OR. Both straps are exercised in one run, so an address that is live under one strap is shown to be dead under the other.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam int WIN_SPAN = 20;
  localparam int OFF_W    = $clog2(WIN_SPAN);
  localparam int LA_REGS  = 4;
  localparam int IRQ_N    = 4;

  localparam logic [OFF_W-1:0] OFF_RST = OFF_W'(5'h10);
  localparam logic [OFF_W-1:0] OFF_ANA = OFF_W'(5'h11);
  localparam logic [OFF_W-1:0] OFF_DMA = OFF_W'(5'h12);
  localparam logic [OFF_W-1:0] OFF_IEN = OFF_W'(5'h13);

  typedef enum logic [1:0] {
    SRC_DMA_END = 2'd0,
    SRC_ERR     = 2'd1,
    SRC_OUT_RDY = 2'd2,
    SRC_IN_RDY  = 2'd3
  } irq_src_e;

  function automatic logic in_window(input logic [15:0] delta);
    return delta < 16'(WIN_SPAN);
  endfunction

  function automatic logic dir_ready(input logic dir, input logic in_rdy,
                                     input logic out_rdy);
    return dir ? in_rdy : out_rdy;
  endfunction

  function automatic logic irq_any(input logic [IRQ_N-1:0] en,
                                   input logic [IRQ_N-1:0] src);
    return |(en & src);
  endfunction
endpackage

// File: rtl/hbc_addr_dec.sv
module hbc_addr_dec
  import hbc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE0 = 10'h150,
  parameter logic [ADDR_W-1:0] BASE1 = 10'h200
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              base_sel,
  output logic              hit,
  output logic [OFF_W-1:0]  offs
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] delta;

  always_comb begin
    base  = base_sel ? BASE1 : BASE0;
    delta = addr - base;
    hit   = in_window(16'(delta));
    offs  = delta[OFF_W-1:0];
  end
endmodule

// File: rtl/hbc_dma.sv
module hbc_dma
  import hbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_dma,
  input  logic wdir,
  input  logic in_rdy,
  input  logic out_rdy,
  input  logic ack,
  input  logic tc,
  output logic req,
  output logic active,
  output logic dir,
  output logic end_evt
);
  logic last_byte;
  assign last_byte = ack && tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      dir     <= 1'b0;
      end_evt <= 1'b0;
      req     <= 1'b0;
    end else begin
      if (wr_dma) begin
        active  <= 1'b1;
        dir     <= wdir;
        end_evt <= 1'b0;
      end else if (last_byte) begin
        active  <= 1'b0;
        end_evt <= 1'b1;
      end
      req <= active && dir_ready(dir, in_rdy, out_rdy) && !ack;
    end
  end

  // R7
  req_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !req);
  // R7
  req_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> active);
  // R8
  end_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && !wr_dma) |=> (end_evt && !active));
  // R8
  end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dma |=> (!end_evt && active));
endmodule

// File: rtl/hbc_irq.sv
module hbc_irq
  import hbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ien,
  input  logic [IRQ_N-1:0] wen,
  input  logic [IRQ_N-1:0] src,
  output logic [IRQ_N-1:0] ien,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
      irq <= 1'b0;
    end else begin
      if (wr_ien) ien <= wen;
      irq <= irq_any(ien, src);
    end
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |=> !irq);
  // R9
  irq_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |=> !irq);
endmodule

// File: rtl/hbc_top.sv
module hbc_top
  import hbc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NMOD   = 10,
  parameter logic [ADDR_W-1:0] BASE0 = 10'h150,
  parameter logic [ADDR_W-1:0] BASE1 = 10'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              la_cs,
  output logic              la_wr,
  output logic              la_rd,
  output logic [1:0]        la_offs,
  output logic [7:0]        la_wdata,
  input  logic [7:0]        la_rdata,
  input  logic              la_in_rdy,
  input  logic              la_out_rdy,
  input  logic [NMOD-1:0]   mod_err,
  output logic              mod_reset,
  output logic              mod_analyse,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic              dma_tc,
  output logic              irq
);
  logic             hit;
  logic [OFF_W-1:0] offs;
  logic             la_hit, wr_hit;
  logic             wr_rst, wr_ana, wr_dma, wr_ien;
  logic             err_any;
  logic             dma_act, dma_dir, dma_end;
  logic [IRQ_N-1:0] ien, src;

  hbc_addr_dec #(.ADDR_W(ADDR_W), .BASE0(BASE0), .BASE1(BASE1)) u_dec (
    .addr(addr), .base_sel(base_sel), .hit(hit), .offs(offs)
  );

  always_comb begin
    la_hit = hit && (offs < OFF_W'(LA_REGS));
    wr_hit = hit && wr_en;
    wr_rst = wr_hit && (offs == OFF_RST);
    wr_ana = wr_hit && (offs == OFF_ANA);
    wr_dma = wr_hit && (offs == OFF_DMA);
    wr_ien = wr_hit && (offs == OFF_IEN);
    err_any = |mod_err;
  end

  assign la_cs    = la_hit && (wr_en || rd_en);
  assign la_wr    = la_hit && wr_en;
  assign la_rd    = la_hit && rd_en;
  assign la_offs  = offs[1:0];
  assign la_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_reset   <= 1'b0;
      mod_analyse <= 1'b0;
    end else begin
      if (wr_rst) mod_reset   <= wdata[0];
      if (wr_ana) mod_analyse <= wdata[0];
    end
  end

  hbc_dma u_dma (
    .clk(clk), .rst_n(rst_n), .wr_dma(wr_dma), .wdir(wdata[0]),
    .in_rdy(la_in_rdy), .out_rdy(la_out_rdy), .ack(dma_ack), .tc(dma_tc),
    .req(dma_req), .active(dma_act), .dir(dma_dir), .end_evt(dma_end)
  );

  always_comb begin
    src = '0;
    src[SRC_DMA_END] = dma_end;
    src[SRC_ERR]     = err_any;
    src[SRC_OUT_RDY] = la_out_rdy;
    src[SRC_IN_RDY]  = la_in_rdy;
  end

  hbc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_ien(wr_ien), .wen(wdata[IRQ_N-1:0]),
    .src(src), .ien(ien), .irq(irq)
  );

  always_comb begin
    rdata = 8'h00;
    if (hit && rd_en) begin
      if (la_hit)                rdata = la_rdata;
      else if (offs == OFF_RST)  rdata = {7'b0, err_any};
      else if (offs == OFF_DMA)  rdata = {6'b0, dma_act, dma_dir};
    end
  end

  // R1
  no_select_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!la_cs && rdata == 8'h00));
  // R3
  reset_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (mod_reset == $past(wdata[0])));
  // R5
  analyse_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ana |=> (mod_analyse == $past(wdata[0])));
  // R3
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rst |=> $stable(mod_reset));
endmodule

// File: tb/hbc_top_test.sv
`timescale 1ns/100ps
module hbc_top_test;
  localparam int NM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_sel = 1'b0;
  logic [9:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata, la_wdata, la_rdata = '0;
  logic la_cs, la_wr, la_rd;
  logic [1:0] la_offs;
  logic la_in_rdy = 1'b0, la_out_rdy = 1'b0;
  logic [NM-1:0] mod_err = '0;
  logic mod_reset, mod_analyse, dma_req, irq;
  logic dma_ack = 1'b0, dma_tc = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  hbc_top #(.NMOD(NM)) uut (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .la_cs(la_cs), .la_wr(la_wr), .la_rd(la_rd), .la_offs(la_offs),
    .la_wdata(la_wdata), .la_rdata(la_rdata), .la_in_rdy(la_in_rdy),
    .la_out_rdy(la_out_rdy), .mod_err(mod_err), .mod_reset(mod_reset),
    .mod_analyse(mod_analyse), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_tc(dma_tc), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // reference model state
  bit m_rst, m_ana, m_act, m_dir, m_end, m_req, m_irq;
  bit [3:0] m_ien;

  function automatic int offset_of(input logic [9:0] a);
    int d;
    d = int'(a) - (base_sel ? 512 : 336);
    if (d >= 0 && d <= 19) return d;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst <= 0; m_ana <= 0; m_act <= 0; m_dir <= 0; m_end <= 0;
      m_req <= 0; m_irq <= 0; m_ien <= 0;
    end else begin
      int o;
      bit dwr;
      o = wr_en ? offset_of(addr) : -1;
      dwr = (o == 18);
      if (o == 16) m_rst <= wdata[0];
      if (o == 17) m_ana <= wdata[0];
      if (o == 19) m_ien <= wdata[3:0];
      if (dwr) begin
        m_act <= 1; m_dir <= wdata[0]; m_end <= 0;
      end else if (dma_ack && dma_tc) begin
        m_act <= 0; m_end <= 1;
      end
      m_req <= m_act && !dma_ack && (m_dir ? la_in_rdy : la_out_rdy);
      m_irq <= (m_ien[0] && m_end) || (m_ien[1] && (mod_err != 0)) ||
               (m_ien[2] && la_out_rdy) || (m_ien[3] && la_in_rdy);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 mod_reset", mod_reset, m_rst);
    chk("R5 mod_analyse", mod_analyse, m_ana);
    chk("R7 dma_req", dma_req, m_req);
    chk("R9 irq", irq, m_irq);
  end

  function automatic int exp_read(input logic [9:0] a);
    int o;
    o = offset_of(a);
    if (o < 0) return 0;
    if (o < 4) return la_rdata;
    if (o == 16) return (mod_err != 0) ? 1 : 0;
    if (o == 18) return {m_act, m_dir};
    return 0;
  endfunction

  task automatic bus_wr(input logic [9:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    #1;
    if (offset_of(a) >= 0 && offset_of(a) < 4) begin
      chk({req, " la_wr"}, la_wr, 1);
      chk({req, " la_offs"}, la_offs, offset_of(a));
      chk({req, " la_wdata"}, la_wdata, d);
    end else chk({req, " la_cs"}, la_cs, 0);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(input logic [9:0] a, input string req);
    @(negedge clk);
    addr = a; rd_en = 1;
    #1;
    chk({req, " rdata"}, rdata, exp_read(a));
    chk({req, " la_rd"}, la_rd, (offset_of(a) >= 0 && offset_of(a) < 4) ? 1 : 0);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic ack_byte(input bit last);
    int n = 0;
    @(negedge clk);
    while (!dma_req && n < 50) begin @(negedge clk); n++; end
    chk("R7 request seen", dma_req, 1);
    dma_ack = 1; dma_tc = last;
    @(negedge clk);
    dma_ack = 0; dma_tc = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R10 reset state
    chk("R10 reset mod_reset", mod_reset, 0);
    chk("R10 reset mod_analyse", mod_analyse, 0);
    chk("R10 reset dma_req", dma_req, 0);
    chk("R10 reset irq", irq, 0);
    rst_n = 1;
    idle(2);

    // R2 adaptor pass-through at base 0x150
    la_rdata = 8'hA5;
    bus_rd(10'h150, "R2");
    la_rdata = 8'h3C;
    bus_rd(10'h153, "R2");
    bus_wr(10'h151, 8'h77, "R2");

    // R3 / R5 control lines
    bus_wr(10'h160, 8'h01, "R3");
    idle(1);
    bus_wr(10'h161, 8'hFF, "R5");
    idle(1);
    bus_wr(10'h161, 8'h00, "R5");

    // R4 error readback
    mod_err = 3'b010; bus_rd(10'h160, "R4");
    mod_err = 3'b100; bus_rd(10'h160, "R4");
    mod_err = 3'b000; bus_rd(10'h160, "R4");

    // R1 other window ignored while strap low
    bus_wr(10'h210, 8'h00, "R1");
    idle(1);
    chk("R1 foreign window write", mod_reset, 1);
    bus_rd(10'h200, "R1");
    bus_rd(10'h164, "R1");
    bus_wr(10'h14F, 8'h00, "R1");

    // R1 strap high
    base_sel = 1;
    bus_wr(10'h160, 8'h00, "R1");
    chk("R1 old window dead", mod_reset, 1);
    bus_wr(10'h210, 8'h00, "R1");
    idle(1);
    chk("R1 new window live", mod_reset, 0);
    la_rdata = 8'h5A;
    bus_rd(10'h202, "R2");

    // R10 undefined offsets
    bus_wr(10'h208, 8'hFF, "R10");
    bus_wr(10'h20F, 8'hFF, "R10");
    bus_rd(10'h208, "R10");
    bus_rd(10'h211, "R10");
    bus_rd(10'h213, "R10");
    bus_rd(10'h212, "R10");

    // R6/R7 host-to-board transfer
    la_out_rdy = 1;
    bus_wr(10'h212, 8'h00, "R6");
    bus_rd(10'h212, "R6");
    ack_byte(0);
    ack_byte(0);
    la_out_rdy = 0; idle(4);
    chk("R7 held off when not ready", dma_req, 0);
    la_in_rdy = 1; idle(3);
    chk("R6 wrong direction ignored", dma_req, 0);
    la_in_rdy = 0;
    la_out_rdy = 1;
    ack_byte(1);
    idle(2);
    chk("R8 transfer ended", dma_req, 0);
    bus_rd(10'h212, "R8");

    // R9 end-of-transfer interrupt
    la_out_rdy = 0;
    bus_wr(10'h213, 8'h01, "R9");
    idle(2);
    chk("R9 end interrupt", irq, 1);

    // R6/R8 board-to-host transfer clears the event
    la_in_rdy = 1;
    bus_wr(10'h212, 8'h01, "R8");
    idle(2);
    chk("R8 event cleared", irq, 0);
    bus_rd(10'h212, "R6");
    ack_byte(0);
    ack_byte(1);
    la_in_rdy = 0;
    idle(2);

    // R9 other sources
    bus_wr(10'h213, 8'h02, "R9");
    mod_err = 3'b001; idle(3);
    chk("R9 error interrupt", irq, 1);
    mod_err = 3'b000;
    bus_wr(10'h213, 8'h04, "R9");
    la_out_rdy = 1; idle(3);
    chk("R9 out ready interrupt", irq, 1);
    la_out_rdy = 0;
    bus_wr(10'h213, 8'h08, "R9");
    la_in_rdy = 1; idle(3);
    chk("R9 in ready interrupt", irq, 1);
    bus_wr(10'h213, 8'h00, "R9");
    idle(3);
    chk("R9 masked", irq, 0);
    la_in_rdy = 0;

    // R10 bus reset clears state
    bus_wr(10'h210, 8'h01, "R3");
    bus_wr(10'h212, 8'h01, "R6");
    @(negedge clk); rst_n = 0;
    #1;
    chk("R10 mid reset mod_reset", mod_reset, 0);
    chk("R10 mid reset dma_req", dma_req, 0);
    @(negedge clk); rst_n = 1;
    bus_rd(10'h212, "R10");
    idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule